// File: doc/BRIEF.md
# Tachometer Speed Discriminator with Phase Comparator

This block closes the digital half of a constant-speed motor loop. It runs on a reference clock and receives a one-cycle pulse for every rising edge of the tachometer signal, already synchronized to that clock. A prescaler divides the reference by 16 into ticks. The block counts ticks between consecutive tachometer edges and compares each period with a target of 512 ticks or 1024 ticks, chosen by a select input. The target tachometer rate is therefore the reference rate divided by 16 times the target.

The block has three result paths. A speed-error path emits an accelerate or decelerate request whose length equals the period error, and it updates once for every two tachometer periods. A lock flag, active low, reports whether each measured period lies within one sixteenth (6.25 %) of the target. A three-state phase-frequency detector compares a divided reference, which wraps once per target period, with the tachometer edges. An external integrator filters all of these outputs. If the tachometer stops, the period counter saturates and the block requests full acceleration.

Top module: `fg_speed_loop`

## Requirements
- R1: While reset is high and in the first cycle after it: `lock_n`=1, `spd_drive`=0, `spd_accel`=0, `ph_up`=0, `ph_dn`=0.
- R2: One tick is 16 clocks. A period is the number of ticks between two `fg_rise` pulses. The target is 512 ticks when `sel_short`=1 and 1024 ticks when `sel_short`=0, taken from the select value at the closing edge.
- R3: The first `fg_rise` after reset, and the first `fg_rise` that ends a stall, only start a measurement. They leave the speed-error and lock outputs unchanged.
- R4: The 2nd, 4th, 6th and later valid edges after arming load a speed-error pulse. `spd_drive`=1 from the clock after the edge for 16 × |period − target| clocks. `spd_accel`=1 when the period is longer than the target and 0 when it is shorter. A period with zero error gives no pulse.
- R5: A valid edge that falls between loading edges starts no speed-error pulse.
- R6: On every valid edge, `lock_n` is set to 0 when |period − target| ≤ target/16 (32 or 64 ticks) and to 1 otherwise. The new value is visible one clock after the edge.
- R7: After 2 × target ticks with no `fg_rise`, the block forces `spd_drive`=1, `spd_accel`=1 and `lock_n`=1 until the next `fg_rise`. That edge clears the stall.
- R8: The reference divider wraps every 16 × target clocks, starting from reset. `ph_up` is set one clock after a wrap and `ph_dn` one clock after `fg_rise`. When both are pending, both return to 0. The two outputs are never both 1.
- R9: `spd_accel` is 0 whenever `spd_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| fg_rise | input | 1 | One-cycle pulse per synchronized tachometer rising edge |
| sel_short | input | 1 | 1 selects the 512-tick target, 0 the 1024-tick target |
| spd_drive | output | 1 | Speed-error output enable |
| spd_accel | output | 1 | Speed-error direction: 1 accelerate, 0 decelerate |
| lock_n | output | 1 | Active-low lock indication |
| ph_up | output | 1 | Phase detector: reference ahead of tachometer |
| ph_dn | output | 1 | Phase detector: tachometer ahead of reference |

## Verification
Each registered result appears one clock after its cause. After an edge, the enable and lock values can be read at the next falling clock. A speed-error pulse ends exactly 16 × |error| clocks later, and a stall shows up exactly 2 × target × 16 clocks after the last edge. To sample at those instants, the bench places every tachometer edge an exact number of clocks after the previous one and counts falling edges since that edge. The phase-detector checks are placed against the reference wrap points, which are counted from the release of reset.

// File: rtl/fgsl_pkg.sv
package fgsl_pkg;

    localparam int PRE_DIV    = 16;
    localparam int CNT_SEL_HI = 512;
    localparam int CNT_SEL_LO = 1024;
    localparam int WIN_SHIFT  = 4;

    localparam int PRE_W   = $clog2(PRE_DIV);
    localparam int TICK_W  = $clog2(2 * CNT_SEL_LO + 1);
    localparam int PULSE_W = TICK_W + PRE_W;
    localparam int REF_W   = $clog2(PRE_DIV * CNT_SEL_LO + 1);

    typedef logic [TICK_W-1:0]  tick_t;
    typedef logic [PULSE_W-1:0] pulse_t;
    typedef logic [REF_W-1:0]   ref_t;

    typedef struct packed {
        logic  edge_ok;
        logic  stall;
        tick_t meas;
    } per_res_t;

    typedef enum logic [1:0] {
        PFD_IDLE = 2'b00,
        PFD_UP   = 2'b01,
        PFD_DN   = 2'b10
    } pfd_st_t;

    function automatic tick_t target_ticks(input logic sel_short);
        return sel_short ? tick_t'(CNT_SEL_HI) : tick_t'(CNT_SEL_LO);
    endfunction

endpackage

// File: rtl/fgsl_period.sv
module fgsl_period
    import fgsl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     fg_rise,
    input  logic     sel_short,
    output per_res_t res
);
    logic [PRE_W-1:0] pre;
    tick_t            per;
    logic             armed;
    logic             tick;
    tick_t            sat;

    assign sat  = target_ticks(sel_short) << 1;
    assign tick = (pre == PRE_W'(PRE_DIV - 1));

    always_comb begin
        res.meas    = per + tick_t'(tick);
        res.stall   = armed && (per >= sat);
        res.edge_ok = fg_rise && armed && !res.stall;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre   <= '0;
            per   <= '0;
            armed <= 1'b0;
        end else if (fg_rise) begin
            pre   <= '0;
            per   <= '0;
            armed <= 1'b1;
        end else begin
            pre <= tick ? '0 : pre + 1'b1;
            if (tick && (per < sat))
                per <= per + 1'b1;
        end
    end
endmodule

// File: rtl/fgsl_discrim.sv
module fgsl_discrim
    import fgsl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     fg_rise,
    input  logic     sel_short,
    input  per_res_t res,
    output logic     spd_drive,
    output logic     spd_accel,
    output logic     lock_n
);
    tick_t                   tgt;
    tick_t                   win;
    tick_t                   mag;
    logic signed [TICK_W:0]  diff;
    logic                    slow;
    logic                    in_win;
    logic                    slot;
    logic                    lock_q;
    logic                    dir_q;
    pulse_t                  pcnt;

    always_comb begin
        tgt    = target_ticks(sel_short);
        win    = tgt >> WIN_SHIFT;
        diff   = $signed({1'b0, res.meas}) - $signed({1'b0, tgt});
        slow   = !diff[TICK_W] && (diff != '0);
        mag    = diff[TICK_W] ? tick_t'(-diff) : tick_t'(diff);
        in_win = (mag <= win);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot   <= 1'b0;
            lock_q <= 1'b1;
            dir_q  <= 1'b0;
            pcnt   <= '0;
        end else begin
            pcnt <= (pcnt != '0) ? pcnt - 1'b1 : '0;
            if (res.stall) begin
                lock_q <= 1'b1;
                slot   <= 1'b0;
                pcnt   <= '0;
            end else if (res.edge_ok) begin
                lock_q <= !in_win;
                slot   <= ~slot;
                if (!slot) begin
                    pcnt  <= pulse_t'(mag) * pulse_t'(PRE_DIV);
                    dir_q <= slow;
                end
            end else if (fg_rise) begin
                slot <= 1'b0;
            end
        end
    end

    assign spd_drive = res.stall || (pcnt != '0);
    assign spd_accel = res.stall || ((pcnt != '0) && dir_q);
    assign lock_n    = lock_q || res.stall;
endmodule

// File: rtl/fgsl_pfd.sv
module fgsl_pfd
    import fgsl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fg_rise,
    input  logic sel_short,
    output logic ph_up,
    output logic ph_dn
);
    ref_t    ref_cnt;
    ref_t    lim;
    logic    ref_hit;
    pfd_st_t st;
    pfd_st_t st_nx;
    logic    up_pend;
    logic    dn_pend;

    assign lim     = ref_t'(target_ticks(sel_short)) * ref_t'(PRE_DIV) - ref_t'(1);
    assign ref_hit = (ref_cnt >= lim);

    always_comb begin
        up_pend = (st == PFD_UP) || ref_hit;
        dn_pend = (st == PFD_DN) || fg_rise;
        if (up_pend && dn_pend) st_nx = PFD_IDLE;
        else if (up_pend)       st_nx = PFD_UP;
        else if (dn_pend)       st_nx = PFD_DN;
        else                    st_nx = PFD_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_cnt <= '0;
            st      <= PFD_IDLE;
        end else begin
            ref_cnt <= ref_hit ? '0 : ref_cnt + 1'b1;
            st      <= st_nx;
        end
    end

    assign ph_up = (st == PFD_UP);
    assign ph_dn = (st == PFD_DN);
endmodule

// File: rtl/fg_speed_loop.sv
module fg_speed_loop
    import fgsl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fg_rise,
    input  logic sel_short,
    output logic spd_drive,
    output logic spd_accel,
    output logic lock_n,
    output logic ph_up,
    output logic ph_dn
);
    per_res_t res;

    fgsl_period u_period (
        .clk       (clk),
        .rst       (rst),
        .fg_rise   (fg_rise),
        .sel_short (sel_short),
        .res       (res)
    );

    fgsl_discrim u_discrim (
        .clk       (clk),
        .rst       (rst),
        .fg_rise   (fg_rise),
        .sel_short (sel_short),
        .res       (res),
        .spd_drive (spd_drive),
        .spd_accel (spd_accel),
        .lock_n    (lock_n)
    );

    fgsl_pfd u_pfd (
        .clk       (clk),
        .rst       (rst),
        .fg_rise   (fg_rise),
        .sel_short (sel_short),
        .ph_up     (ph_up),
        .ph_dn     (ph_dn)
    );
endmodule

// File: rtl/fgsl_chk.sv
module fgsl_chk (
    input logic clk,
    input logic rst,
    input logic fg_rise,
    input logic spd_drive,
    input logic spd_accel,
    input logic lock_n,
    input logic ph_up,
    input logic ph_dn
);
    a_r8_pfd_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ph_up && ph_dn));

    a_r8_dn_follows_fg: assert property (@(posedge clk) disable iff (rst)
        $rose(ph_dn) |-> $past(fg_rise));

    a_r9_idle_accel_low: assert property (@(posedge clk) disable iff (rst)
        !spd_drive |-> !spd_accel);

    a_r4_drive_start: assert property (@(posedge clk) disable iff (rst)
        $rose(spd_drive) |-> ($past(fg_rise) || (spd_accel && lock_n)));

    a_r6_lock_on_edge: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_n) |-> $past(fg_rise));
endmodule

bind fg_speed_loop fgsl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .fg_rise   (fg_rise),
    .spd_drive (spd_drive),
    .spd_accel (spd_accel),
    .lock_n    (lock_n),
    .ph_up     (ph_up),
    .ph_dn     (ph_dn)
);

// File: tb/tb_fg_speed_loop.sv
module tb_fg_speed_loop;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fg_rise = 1'b0;
    logic sel_short = 1'b1;
    logic spd_drive, spd_accel, lock_n, ph_up, ph_dn;

    int checks = 0;
    int fails = 0;
    int since = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    fg_speed_loop dut (
        .clk       (clk),
        .rst       (rst),
        .fg_rise   (fg_rise),
        .sel_short (sel_short),
        .spd_drive (spd_drive),
        .spd_accel (spd_accel),
        .lock_n    (lock_n),
        .ph_up     (ph_up),
        .ph_dn     (ph_dn)
    );

    typedef struct packed {
        logic        sel;
        logic [11:0] per;
        logic        exp_lock_n;
        logic        exp_accel;
        logic [11:0] mag;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{1'b1, 12'd545,  1'b1, 1'b1, 12'd33},
        '{1'b1, 12'd480,  1'b0, 1'b0, 12'd32},
        '{1'b1, 12'd479,  1'b1, 1'b0, 12'd33},
        '{1'b0, 12'd1089, 1'b1, 1'b1, 12'd65},
        '{1'b0, 12'd960,  1'b0, 1'b0, 12'd64}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
        since += n;
    endtask

    task automatic fg_edge(input int p);
        repeat (16 * p - since - 1) @(negedge clk);
        fg_rise = 1'b1;
        @(negedge clk);
        fg_rise = 1'b0;
        since = 0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk("R1", "lock_n", lock_n, 1);
        chk("R1", "spd_drive", spd_drive, 0);
        chk("R1", "spd_accel", spd_accel, 0);
        chk("R1", "ph_up|ph_dn", ph_up | ph_dn, 0);
        rst = 1'b0;

        // reference wraps after 8192 clocks with the 512 target
        repeat (8191) @(negedge clk);
        chk("R8", "ph_up before wrap", ph_up, 0);
        @(negedge clk);
        chk("R8", "ph_up after wrap", ph_up, 1);
        chk("R8", "ph_dn after wrap", ph_dn, 0);
        fg_rise = 1'b1;
        @(negedge clk);
        fg_rise = 1'b0;
        since = 0;
        chk("R8", "both cleared", ph_up | ph_dn, 0);
        chk("R3", "arming edge drive", spd_drive, 0);
        chk("R3", "arming edge lock_n", lock_n, 1);

        fg_edge(500);
        chk("R8", "ph_dn after early fg", ph_dn, 1);
        chk("R8", "ph_up after early fg", ph_up, 0);
        chk("R6", "lock_n err -12", lock_n, 0);
        chk("R4", "drive err -12", spd_drive, 1);
        chk("R4", "accel err -12", spd_accel, 0);
        waitn(190);
        chk("R8", "ph_dn held", ph_dn, 1);
        waitn(1);
        chk("R8", "cleared on ref wrap", ph_up | ph_dn, 0);
        chk("R4", "drive last clock", spd_drive, 1);
        waitn(1);
        chk("R4", "drive ended", spd_drive, 0);
        chk("R9", "accel idle", spd_accel, 0);
        fg_edge(500);
        chk("R5", "no pulse between loads", spd_drive, 0);

        for (int i = 0; i < 5; i++) begin
            vec_t v;
            v = VEC[i];
            sel_short = v.sel;
            fg_edge(int'(v.per));
            chk("R6", "lock_n vector", lock_n, v.exp_lock_n);
            chk("R4", "drive vector", spd_drive, 1);
            chk("R4", "accel vector", spd_accel, v.exp_accel);
            waitn(16 * int'(v.mag) - 1);
            chk("R2", "pulse length last", spd_drive, 1);
            waitn(1);
            chk("R2", "pulse length end", spd_drive, 0);
            chk("R9", "accel idle vector", spd_accel, 0);
            fg_edge(int'(v.per));
            chk("R5", "second edge no pulse", spd_drive, 0);
            chk("R6", "lock_n second edge", lock_n, v.exp_lock_n);
        end

        sel_short = 1'b1;
        waitn(16383);
        chk("R7", "no stall yet", spd_drive, 0);
        waitn(1);
        chk("R7", "stall drive", spd_drive, 1);
        chk("R7", "stall accel", spd_accel, 1);
        chk("R7", "stall lock_n", lock_n, 1);
        waitn(100);
        chk("R7", "stall held", spd_drive, 1);
        fg_rise = 1'b1;
        @(negedge clk);
        fg_rise = 1'b0;
        since = 0;
        chk("R7", "stall cleared", spd_drive, 0);
        chk("R3", "re-arm lock_n", lock_n, 1);
        fg_edge(512);
        chk("R6", "exact target lock_n", lock_n, 0);
        chk("R4", "zero error no pulse", spd_drive, 0);
        fg_edge(600);
        chk("R6", "unlock on non-loading edge", lock_n, 1);
        chk("R5", "non-loading edge no pulse", spd_drive, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule